// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus whose data line is held low by a slave that lost track of a transfer. Once started, it toggles the clock line at a rate set by an external tick, up to a programmed number of pulses. After each high phase it looks at the data line. It can stop pulsing as soon as the data line reads high, and it can close the sequence with a STOP condition. When it finishes, it records whether the data line came free and raises a done interrupt.

Software sets up the pulse limit and the options in a shadow copy of the configuration. A separate load command copies the shadow into the active settings. The copy waits while a recovery is running, so the settings in use never change in the middle of a sequence. Both bus lines are open-drain. An output of 1 pulls the line low, and the sense inputs carry the line levels, already synchronized to the clock.

Top module: `i2c_bus_recovery`

## Requirements
- R1: After reset, both drive outputs are 0, the interrupt output is 0, and the status, load and interrupt registers read 0. The configuration register (address 0) reads 0x00120000: the default limit of 18 pulses, no options, and an idle run bit.
- R2: The configuration register at address 0 stores the pulse limit in bits 23:16, the STOP option in bit 2 and the early-exit option in bit 1, and reads these shadow values back. Bit 0 of the same register reads 1 only while a recovery runs.
- R3: A write of 1 to bit 0 of the load register (address 2) copies the shadow settings into the active settings. The load bit reads 1 until the copy is made. No copy is made while a recovery runs, and a recovery always uses the active settings.
- R4: A write of 1 to bit 0 of the configuration register starts a recovery when the block is idle. The same write made while a recovery is running starts nothing and leaves the current recovery unchanged.
- R5: Each pulse pulls the clock low for one tick interval and then releases it. The data line is sampled on a tick in the high phase, and only once the clock line reads high. A slave stretching the clock therefore lengthens the high phase.
- R6: With early exit off, exactly the programmed number of pulses is issued. The result is the data level at the last sample.
- R7: With early exit on, pulsing stops at the first sample that finds the data line high.
- R8: If every allowed pulse finds the data line low, the result is "not freed" (status bit 0 = 0).
- R9: With the STOP option on, the block pulls the clock low after the last sample, then pulls the data line low, then releases the clock, and then releases the data line. A pulled-low data line is only asserted while the clock is pulled low, so no bus condition other than the final STOP appears.
- R10: Status bit 0 (address 1) clears when a recovery starts. It takes the result when the recovery ends and holds it until the next start.
- R11: Completion sets bit 11 of the interrupt register (address 3) and drives the interrupt output high. Writing 1 to bit 11 clears it, and writing 0 to bit 11 has no effect.
- R12: A pulse limit of 0 issues no pulses. The recovery completes at once, and the result is the data level at the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle strobe that paces each half pulse |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| scl_in | input | 1 | Sensed clock line level |
| sda_in | input | 1 | Sensed data line level |
| scl_pull | output | 1 | 1 pulls the clock line low |
| sda_pull | output | 1 | 1 pulls the data line low |
| irq_done | output | 1 | Completion interrupt |

## Verification
The assertions assume that the sense inputs are synchronous to the clock. They also assume that the clock line can only read high when the block is not pulling it, and that tick is a single-cycle strobe. The bench drives the lines through a wired-AND model: the line level is the AND of the block's release and the slave's release. Its slave model changes the data line only after it sees the clock line fall, and it stretches the clock only by holding the line low after a release. Register writes come in single-cycle strobes between clock edges, one access at a time.

// File: rtl/brc_pkg.sv
// Shared types and register layout for the bus recovery sequencer.
// Assumes a 32-bit register port with four word addresses.
package brc_pkg;

    localparam int DATA_W       = 32;
    localparam int ADDR_W       = 2;
    localparam int THR_W        = 8;
    localparam int THR_LSB      = 16;
    localparam int CFG_RUN_BIT  = 0;
    localparam int CFG_TERM_BIT = 1;
    localparam int CFG_STOP_BIT = 2;
    localparam int LOAD_BIT     = 0;
    localparam int FREED_BIT    = 0;
    localparam int IRQ_DONE_BIT = 11;

    localparam logic [ADDR_W-1:0] A_CFG   = 2'd0;
    localparam logic [ADDR_W-1:0] A_STAT  = 2'd1;
    localparam logic [ADDR_W-1:0] A_LOAD  = 2'd2;
    localparam logic [ADDR_W-1:0] A_IRQ   = 2'd3;

    // Recovery settings, held both as shadow and as active copy
    typedef struct packed {
        logic [THR_W-1:0] limit;
        logic             stop_en;
        logic             early_exit;
    } rec_cfg_t;

    // Sequencer phases
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CLK_LOW,
        PH_CLK_HIGH,
        PH_STP_CLK_LOW,
        PH_STP_DAT_LOW,
        PH_STP_CLK_REL,
        PH_STP_DAT_REL
    } rec_phase_t;

endpackage

// File: rtl/brc_regs.sv
// Register file of the recovery sequencer: shadow and active settings,
// load handshake, sticky result and completion interrupt.
// Assumes done_i is a single-cycle strobe from the sequencer and that the
// sequencer only reads the active settings.
module brc_regs #(
    parameter int DEF_PULSES = 18
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wen,
    input  logic [brc_pkg::ADDR_W-1:0]  addr,
    input  logic [brc_pkg::DATA_W-1:0]  wdata,
    output logic [brc_pkg::DATA_W-1:0]  rdata,
    input  logic                        busy_i,
    input  logic                        done_i,
    input  logic                        freed_i,
    output logic                        start_o,
    output brc_pkg::rec_cfg_t           act_o,
    output logic                        irq_o
);
    import brc_pkg::*;

    localparam logic [THR_W-1:0] DEF_LIMIT = THR_W'(DEF_PULSES);

    rec_cfg_t shadow_q;
    rec_cfg_t active_q;
    logic     load_q;
    logic     freed_q;
    logic     irq_q;

    logic wr_cfg, wr_load, wr_irq, copy_now;

    // Decode write strobes per register
    assign wr_cfg  = wen && (addr == A_CFG);
    assign wr_load = wen && (addr == A_LOAD) && wdata[LOAD_BIT];
    assign wr_irq  = wen && (addr == A_IRQ) && wdata[IRQ_DONE_BIT];

    // Start only from idle; a run request while busy is dropped
    assign start_o  = wr_cfg && wdata[CFG_RUN_BIT] && !busy_i;
    // Pending load is applied only while no recovery is or becomes active
    assign copy_now = load_q && !busy_i && !start_o;

    // Shadow settings take every configuration write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '{limit: DEF_LIMIT, stop_en: 1'b0, early_exit: 1'b0};
        end else if (wr_cfg) begin
            shadow_q.limit      <= wdata[THR_LSB +: THR_W];
            shadow_q.stop_en    <= wdata[CFG_STOP_BIT];
            shadow_q.early_exit <= wdata[CFG_TERM_BIT];
        end
    end

    // Load handshake: pending flag and copy into the active settings
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= '{limit: DEF_LIMIT, stop_en: 1'b0, early_exit: 1'b0};
            load_q   <= 1'b0;
        end else begin
            if (copy_now) begin
                active_q <= shadow_q;
            end
            if (wr_load) begin
                load_q <= 1'b1;
            end else if (copy_now) begin
                load_q <= 1'b0;
            end
        end
    end

    // Sticky result: cleared at start, updated at completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freed_q <= 1'b0;
        end else if (done_i) begin
            freed_q <= freed_i;
        end else if (start_o) begin
            freed_q <= 1'b0;
        end
    end

    // Completion interrupt, write-one-to-clear, set wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (done_i) begin
            irq_q <= 1'b1;
        end else if (wr_irq) begin
            irq_q <= 1'b0;
        end
    end

    // Read multiplexer
    always_comb begin
        rdata = '0;
        case (addr)
            A_CFG: begin
                rdata[THR_LSB +: THR_W] = shadow_q.limit;
                rdata[CFG_STOP_BIT]     = shadow_q.stop_en;
                rdata[CFG_TERM_BIT]     = shadow_q.early_exit;
                rdata[CFG_RUN_BIT]      = busy_i;
            end
            A_STAT:  rdata[FREED_BIT]    = freed_q;
            A_LOAD:  rdata[LOAD_BIT]     = load_q;
            default: rdata[IRQ_DONE_BIT] = irq_q;
        endcase
    end

    assign act_o = active_q;
    assign irq_o = irq_q;

    // R3: active settings do not move while a recovery runs
    a_r3_active_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && $past(busy_i)) |-> $stable(active_q));

    // R11: the interrupt only rises after a completion
    a_r11_irq_from_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(done_i));

    // R10: the result changes only at a start or a completion
    a_r10_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(freed_q) |-> $past(done_i || start_o));

    // R4: no start is accepted while a recovery is running
    a_r4_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |-> !start_o);

endmodule

// File: rtl/brc_seq.sv
// Recovery sequencer: issues clock pulses paced by tick, samples the data
// line after each high phase, and optionally ends with a STOP condition.
// Assumes tick is a one-cycle strobe, the sense inputs are synchronous,
// and the settings stay stable while busy_o is high.
module brc_seq (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              start_i,
    input  brc_pkg::rec_cfg_t cfg_i,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_pull,
    output logic              sda_pull,
    output logic              busy_o,
    output logic              done_o,
    output logic              freed_o
);
    import brc_pkg::*;

    rec_phase_t       ph_q, ph_d;
    logic [THR_W-1:0] cnt_q, cnt_d;
    logic             res_q, res_d;
    logic [THR_W:0]   cnt_inc;
    logic             sample_ok, last_pulse, finish_pulses;

    // Pulse bookkeeping for the sample decision
    assign cnt_inc       = {1'b0, cnt_q} + 1'b1;
    assign sample_ok     = tick_i && scl_in;
    assign last_pulse    = (cnt_inc == {1'b0, cfg_i.limit});
    assign finish_pulses = last_pulse || (sda_in && cfg_i.early_exit);

    // Next-phase, count and result logic
    always_comb begin
        ph_d   = ph_q;
        cnt_d  = cnt_q;
        res_d  = res_q;
        done_o = 1'b0;
        case (ph_q)
            PH_IDLE: begin
                if (start_i) begin
                    cnt_d = '0;
                    if (cfg_i.limit == '0) begin
                        done_o = 1'b1;
                    end else begin
                        ph_d = PH_CLK_LOW;
                    end
                end
            end
            PH_CLK_LOW: begin
                if (tick_i) ph_d = PH_CLK_HIGH;
            end
            PH_CLK_HIGH: begin
                if (sample_ok) begin
                    cnt_d = cnt_inc[THR_W-1:0];
                    res_d = sda_in;
                    if (finish_pulses) begin
                        if (cfg_i.stop_en) begin
                            ph_d = PH_STP_CLK_LOW;
                        end else begin
                            ph_d   = PH_IDLE;
                            done_o = 1'b1;
                        end
                    end else begin
                        ph_d = PH_CLK_LOW;
                    end
                end
            end
            PH_STP_CLK_LOW: begin
                if (tick_i) ph_d = PH_STP_DAT_LOW;
            end
            PH_STP_DAT_LOW: begin
                if (tick_i) ph_d = PH_STP_CLK_REL;
            end
            PH_STP_CLK_REL: begin
                if (sample_ok) ph_d = PH_STP_DAT_REL;
            end
            PH_STP_DAT_REL: begin
                if (tick_i) begin
                    ph_d   = PH_IDLE;
                    done_o = 1'b1;
                end
            end
            default: ph_d = PH_IDLE;
        endcase
    end

    // Phase, count and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
            res_q <= 1'b0;
        end else begin
            ph_q  <= ph_d;
            cnt_q <= cnt_d;
            res_q <= res_d;
        end
    end

    // Line drive decoded from the registered phase
    assign scl_pull = (ph_q == PH_CLK_LOW) || (ph_q == PH_STP_CLK_LOW) ||
                      (ph_q == PH_STP_DAT_LOW);
    assign sda_pull = (ph_q == PH_STP_DAT_LOW) || (ph_q == PH_STP_CLK_REL);
    assign busy_o   = (ph_q != PH_IDLE);
    assign freed_o  = (ph_q == PH_STP_DAT_REL) ? res_q : sda_in;

    // R9: data is pulled low only while the clock is already held low
    a_r9_dat_low_under_clk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> ($past(scl_pull) && scl_pull));

    // R9: data is released (STOP) only with the clock released
    a_r9_stop_clk_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pull) |-> !scl_pull);

    // R5: a high phase is held while the clock line reads low
    a_r5_stretch_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_CLK_HIGH && !scl_in) |=> (ph_q == PH_CLK_HIGH));

    // R1: idle means both lines released
    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!scl_pull && !sda_pull));

    // R4: a completion always returns the sequencer to idle
    a_r4_done_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

endmodule

// File: rtl/i2c_bus_recovery.sv
// Top of the bus recovery sequencer: register file plus pulse sequencer.
// Assumes scl_in/sda_in are synchronized and the bus is open-drain.
module i2c_bus_recovery #(
    parameter int DEF_PULSES = 18
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tick,
    input  logic                        reg_wen,
    input  logic [brc_pkg::ADDR_W-1:0]  reg_addr,
    input  logic [brc_pkg::DATA_W-1:0]  reg_wdata,
    output logic [brc_pkg::DATA_W-1:0]  reg_rdata,
    input  logic                        scl_in,
    input  logic                        sda_in,
    output logic                        scl_pull,
    output logic                        sda_pull,
    output logic                        irq_done
);
    import brc_pkg::*;

    logic     busy, done, freed, start;
    rec_cfg_t active;

    brc_regs #(.DEF_PULSES(DEF_PULSES)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wen     (reg_wen),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .busy_i  (busy),
        .done_i  (done),
        .freed_i (freed),
        .start_o (start),
        .act_o   (active),
        .irq_o   (irq_done)
    );

    brc_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .start_i  (start),
        .cfg_i    (active),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_pull (scl_pull),
        .sda_pull (sda_pull),
        .busy_o   (busy),
        .done_o   (done),
        .freed_o  (freed)
    );

endmodule

// File: tb/test_i2c_bus_recovery.sv
module test_i2c_bus_recovery;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        scl_pull, sda_pull, irq_done;
    logic        scl_line, sda_line, tick;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    // Bus and slave model state
    logic [1:0] tdiv = 2'd0;
    logic scl_p = 1'b1, sda_p = 1'b1;
    int   falls = 0, pulses = 0, stops = 0;
    int   low_run = 0, last_low = 0, high_run = 0, last_high = 0, rel_age = 0;
    logic hold_en = 1'b0, stretch_en = 1'b0;
    int   rel_mark = 0;

    always #2.5 clk = ~clk;

    assign tick     = (tdiv == 2'd3);
    assign scl_line = !scl_pull && !(stretch_en && rel_age < 6);
    assign sda_line = !sda_pull && !(hold_en && falls < rel_mark);

    i2c_bus_recovery i_i2c_bus_recovery (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .scl_in(scl_line), .sda_in(sda_line),
        .scl_pull(scl_pull), .sda_pull(sda_pull), .irq_done(irq_done)
    );

    // Line monitor: pulses, STOPs, falls and phase lengths
    always @(posedge clk) begin
        tdiv  <= tdiv + 2'd1;
        scl_p <= scl_line;
        sda_p <= sda_line;
        if (scl_line && !scl_p && !sda_pull) pulses <= pulses + 1;
        if (sda_line && !sda_p && scl_line && scl_p) stops <= stops + 1;
        if (!scl_line && scl_p) falls <= falls + 1;
        if (scl_pull) begin
            low_run <= low_run + 1;
            rel_age <= 0;
            if (high_run != 0) last_high <= high_run;
            high_run <= 0;
        end else begin
            high_run <= high_run + 1;
            if (rel_age < 100) rel_age <= rel_age + 1;
            if (low_run != 0) last_low <= low_run;
            low_run <= 0;
        end
    end

    task automatic summary_and_end();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
            summary_and_end();
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1 reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] cfg_word(int lim, bit stp, bit term, bit run);
        return (32'(lim) << 16) | (32'(stp) << 2) | (32'(term) << 1) | 32'(run);
    endfunction

    task automatic wait_idle();
        logic [31:0] d;
        for (int i = 0; i < 20000; i++) begin
            rd(2'd0, d);
            if (!d[0]) break;
        end
    endtask

    task automatic set_slave(bit hold, int k, bit stretch);
        @(negedge clk);
        hold_en    = hold;
        rel_mark   = falls + k;
        stretch_en = stretch;
    endtask

    // One recovery: program, optionally load, run, report results
    task automatic run_op(int lim, bit stp, bit term, bit do_load,
                          output int np, output int ns, output int fr);
        logic [31:0] d;
        int p0, s0;
        wr(2'd0, cfg_word(lim, stp, term, 1'b0));
        if (do_load) begin
            wr(2'd2, 32'd1);
            repeat (2) @(negedge clk);
        end
        p0 = pulses; s0 = stops;
        wr(2'd0, cfg_word(lim, stp, term, 1'b1));
        wait_idle();
        repeat (2) @(negedge clk);
        np = pulses - p0; ns = stops - s0;
        rd(2'd1, d);
        fr = int'(d[0]);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(2'd0, d); check("R1 cfg reset", int'(d), 32'h00120000);
        rd(2'd1, d); check("R1 status reset", int'(d), 0);
        rd(2'd2, d); check("R1 load reset", int'(d), 0);
        rd(2'd3, d); check("R1 irq reg reset", int'(d), 0);
        check("R1 lines released", int'({scl_line, sda_line}), 3);
        check("R1 irq out", int'(irq_done), 0);
    endtask

    task automatic t_readback();
        logic [31:0] d;
        wr(2'd0, 32'h00AB0006);
        rd(2'd0, d); check("R2 shadow readback", int'(d), 32'h00AB0006);
        check("R2 no run from bit0=0", int'(scl_pull), 0);
    endtask

    task automatic t_shadow_load();
        int np, ns, fr;
        logic [31:0] d;
        set_slave(1'b1, 1000, 1'b0);
        run_op(5, 1'b0, 1'b0, 1'b0, np, ns, fr);
        check("R3 unloaded shadow ignored, default pulses", np, 18);
        check("R8 stuck bus not freed", fr, 0);
        wr(2'd2, 32'd1);
        rd(2'd2, d); check("R3 load bit pending", int'(d[0]), 1);
        rd(2'd2, d); check("R3 load bit cleared", int'(d[0]), 0);
        run_op(5, 1'b0, 1'b0, 1'b0, np, ns, fr);
        check("R3 loaded limit used", np, 5);
    endtask

    task automatic t_full_count();
        int np, ns, fr;
        set_slave(1'b1, 2, 1'b0);
        run_op(6, 1'b0, 1'b0, 1'b1, np, ns, fr);
        check("R6 all pulses issued", np, 6);
        check("R6 freed at last sample", fr, 1);
        check("R9 no STOP without option", ns, 0);
        check("R5 low phase one tick interval", last_low, 4);
        check("R5 high phase one tick interval", last_high, 4);
    endtask

    task automatic t_early_exit();
        int np, ns, fr;
        set_slave(1'b1, 3, 1'b0);
        run_op(10, 1'b0, 1'b1, 1'b1, np, ns, fr);
        check("R7 stops at first high sample", np, 3);
        check("R7 freed", fr, 1);
    endtask

    task automatic t_stop();
        int np, ns, fr;
        set_slave(1'b1, 1, 1'b0);
        run_op(10, 1'b1, 1'b1, 1'b1, np, ns, fr);
        check("R9 pulses before STOP", np, 1);
        check("R9 one STOP condition", ns, 1);
        check("R9 lines released after STOP", int'({scl_line, sda_line}), 3);
        check("R9 freed result kept", fr, 1);
    endtask

    task automatic t_busy_deferred();
        int p0, np, ns, fr;
        logic [31:0] d;
        set_slave(1'b1, 1000, 1'b0);
        wr(2'd0, cfg_word(12, 1'b0, 1'b0, 1'b0));
        wr(2'd2, 32'd1);
        repeat (2) @(negedge clk);
        p0 = pulses;
        wr(2'd0, cfg_word(12, 1'b0, 1'b0, 1'b1));
        repeat (10) @(negedge clk);
        rd(2'd0, d); check("R4 run bit reads busy", int'(d[0]), 1);
        rd(2'd1, d); check("R10 status cleared at start", int'(d[0]), 0);
        wr(2'd0, cfg_word(3, 1'b0, 1'b0, 1'b1));
        wr(2'd2, 32'd1);
        repeat (8) @(negedge clk);
        rd(2'd2, d); check("R3 load held while busy", int'(d[0]), 1);
        wait_idle();
        repeat (2) @(negedge clk);
        check("R4 restart while busy ignored", pulses - p0, 12);
        rd(2'd2, d); check("R3 load applied after idle", int'(d[0]), 0);
        set_slave(1'b1, 1000, 1'b0);
        run_op(3, 1'b0, 1'b0, 1'b0, np, ns, fr);
        check("R3 deferred load used", np, 3);
    endtask

    task automatic t_status_irq();
        int np, ns, fr;
        logic [31:0] d;
        set_slave(1'b0, 0, 1'b0);
        run_op(4, 1'b0, 1'b1, 1'b1, np, ns, fr);
        check("R10 status set on success", fr, 1);
        wr(2'd3, 32'd0);
        rd(2'd1, d); check("R10 status held", int'(d[0]), 1);
        check("R11 irq output set", int'(irq_done), 1);
        rd(2'd3, d); check("R11 irq bit 11 set", int'(d), 32'h00000800);
        wr(2'd3, 32'h00000800);
        rd(2'd3, d); check("R11 irq cleared", int'(d), 0);
        check("R11 irq output cleared", int'(irq_done), 0);
    endtask

    task automatic t_zero();
        int np, ns, fr;
        set_slave(1'b0, 0, 1'b0);
        run_op(0, 1'b0, 1'b0, 1'b1, np, ns, fr);
        check("R12 zero limit no pulses", np, 0);
        check("R12 zero limit freed high", fr, 1);
        check("R12 zero limit irq", int'(irq_done), 1);
        set_slave(1'b1, 1000, 1'b0);
        run_op(0, 1'b0, 1'b0, 1'b0, np, ns, fr);
        check("R12 zero limit stuck low", fr, 0);
    endtask

    task automatic t_stretch();
        int np, ns, fr;
        set_slave(1'b1, 2, 1'b1);
        run_op(3, 1'b0, 1'b0, 1'b1, np, ns, fr);
        check("R5 stretched pulse count", np, 3);
        check("R5 stretched high phase waits", last_high, 8);
        check("R5 stretched result", fr, 1);
        stretch_en = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_readback();
        t_shadow_load();
        t_full_count();
        t_early_exit();
        t_stop();
        t_busy_deferred();
        t_status_irq();
        t_zero();
        t_stretch();
        summary_and_end();
    end

endmodule